// File: doc/BRIEF.md
# Paged SPD EEPROM I2C Target

This block is an I2C target that models a serial-presence-detect EEPROM holding 512 bytes, organised as two pages of 256 bytes. Only one page is visible through the data address at a time. Through the I2C port the array can only be read. Its contents are loaded through a parallel preload port before the bus is used.

The memory port answers at a 7-bit address made of a fixed 4-bit class code (default binary 1010) followed by a 3-bit strap ID, so strap 4 answers at 0x54. Two further addresses are shared by every device on a bus segment and ignore the strap:

- A write transaction to 0x36 selects page 0, and a write to 0x37 selects page 1.
- A read addressed to 0x36 reports the active page in its address acknowledge.

A random read works in two steps. The controller writes a one-byte offset to the memory address, then issues a repeated START and reads. The target samples SCL and SDA with the system clock and pulls SDA low through an output enable. It never drives SDA high.

Top module: `spd_page_eeprom`

## Requirements
- R1: After reset the active page is page 0, and SDA is released (`sda_oe` = 0).
- R2: Only these addresses are acknowledged: the memory address {class code, `strap_id`} in either direction, 0x36 in either direction, and 0x37 for writes. Any other address gets no acknowledge, and the target leaves SDA released.
- R3: An acknowledged write transaction to 0x36 makes page 0 active, and one to 0x37 makes page 1 active. This happens in every instance on the segment, whatever its strap ID.
- R4: A read addressed to 0x36 is acknowledged (SDA low) when page 0 is active and not acknowledged (SDA high) when page 1 is active. A read addressed to 0x37 is never acknowledged.
- R5: A random read works as follows. The first data byte written to the memory address sets the offset. After a repeated START, the read returns the byte at preload address {page, offset}.
- R6: During a sequential read the offset advances by one after each byte. It wraps from 255 to 0 and stays within the active page.
- R7: Data bytes written after 0x36 or 0x37 are acknowledged, and their values do not change the page.
- R8: Data bytes written to the memory address after the offset byte are acknowledged and leave the array unchanged.
- R9: A read ends when the controller does not acknowledge a byte. The target then releases SDA before the STOP.
- R10: The preload port writes `pre_data` into the byte at `pre_addr`, where bit 8 is the page and bits 7:0 are the offset.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_id | input | 3 | Device ID strap, the low bits of the memory address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When 1, pull SDA low |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 9 | Preload byte address, {page, offset} |
| pre_data | input | 8 | Preload byte value |

## Verification
The hardest case to reach is a page change that must reach both instances, because the change is made on a shared address and one acknowledge on the wired line hides which target gave it. The bench places two instances with different straps on one open-drain line and preloads each with a different pattern. After every page command it reads the same offset from both memory addresses and queries the page. A stale page in either instance then shows up as wrong data. The pointer wrap is reached by setting the offset to 0xFE on page 1 and reading four bytes in one transaction.

// File: rtl/spd_pkg.sv
package spd_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } tgt_state_e;

    typedef enum logic [1:0] {
        K_MEM,
        K_PAGE,
        K_QUERY
    } tgt_kind_e;

    typedef struct packed {
        tgt_state_e         st;
        tgt_kind_e          kind;
        logic               rw;
        logic               first;
        logic               nack;
        logic [3:0]         cnt;
        logic [BYTE_W-1:0]  sr;
        logic               oe;
        logic               page;
        logic [BYTE_W-1:0]  ptr;
    } tgt_regs_t;
endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] scl_d, scl_q;
    logic [CHAIN-1:0] sda_d, sda_q;
    logic scl_p, sda_p;

    always_comb begin
        scl_d = {scl_q[CHAIN-2:0], scl_i};
        sda_d = {sda_q[CHAIN-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_p     = scl_q[STAGES];
    assign sda_p     = sda_q[STAGES];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/spd_store.sv
module spd_store #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/spd_tgt_fsm.sv
module spd_tgt_fsm
    import spd_pkg::*;
#(
    parameter logic [3:0] CLASS_CODE = 4'hA,
    parameter logic [6:0] PAGE0_ADDR = 7'h36,
    parameter logic [6:0] PAGE1_ADDR = 7'h37,
    parameter int         ID_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [ID_W-1:0]   strap_id,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W:0]   rd_addr,
    output logic              sda_oe,
    output logic              page,
    output logic [BYTE_W-1:0] ptr,
    output tgt_state_e        st
);
    localparam int TGT_AW = 4 + ID_W;

    tgt_regs_t q, d;
    logic [TGT_AW-1:0] mem_addr;
    logic hit_mem, hit_pg0, hit_pg1, rd_req;

    always_comb begin
        mem_addr = {CLASS_CODE, strap_id};
        hit_mem  = (q.sr[7:1] == mem_addr);
        hit_pg0  = (q.sr[7:1] == PAGE0_ADDR);
        hit_pg1  = (q.sr[7:1] == PAGE1_ADDR);
        rd_req   = q.sr[0];
        d = q;
        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.sr  = {q.sr[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.rw = rd_req;
                        d.st = ST_IDLE;
                        if (hit_mem) begin
                            d.kind = K_MEM;
                            d.st   = ST_ADDR_ACK;
                            d.oe   = 1'b1;
                        end else if (hit_pg0 && rd_req) begin
                            d.kind = K_QUERY;
                            if (!q.page) begin
                                d.st = ST_ADDR_ACK;
                                d.oe = 1'b1;
                            end
                        end else if ((hit_pg0 || hit_pg1) && !rd_req) begin
                            d.kind = K_PAGE;
                            d.page = hit_pg1;
                            d.st   = ST_ADDR_ACK;
                            d.oe   = 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        if (q.kind == K_QUERY) begin
                            d.st = ST_IDLE;
                        end else if (q.rw) begin
                            d.sr = rd_data;
                            d.oe = ~rd_data[7];
                            d.st = ST_RD_BYTE;
                        end else begin
                            d.first = 1'b1;
                            d.st    = ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise) begin
                        d.sr  = {q.sr[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.oe = 1'b1;
                        d.st = ST_WR_ACK;
                        if (q.kind == K_MEM && q.first) begin
                            d.ptr   = q.sr;
                            d.first = 1'b0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe  = 1'b0;
                            d.ptr = q.ptr + 8'd1;
                            d.st  = ST_RD_ACK;
                        end else begin
                            d.sr = {q.sr[6:0], 1'b0};
                            d.oe = ~q.sr[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (q.nack) begin
                            d.oe = 1'b0;
                            d.st = ST_IDLE;
                        end else begin
                            d.sr  = rd_data;
                            d.oe  = ~rd_data[7];
                            d.cnt = '0;
                            d.st  = ST_RD_BYTE;
                        end
                    end
                end
                default: d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.kind  <= K_MEM;
            q.rw    <= 1'b0;
            q.first <= 1'b0;
            q.nack  <= 1'b0;
            q.cnt   <= '0;
            q.sr    <= '0;
            q.oe    <= 1'b0;
            q.page  <= 1'b0;
            q.ptr   <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_addr = {q.page, q.ptr};
    assign sda_oe  = q.oe;
    assign page    = q.page;
    assign ptr     = q.ptr;
    assign st      = q.st;
endmodule

// File: rtl/spd_page_eeprom.sv
module spd_page_eeprom
    import spd_pkg::*;
#(
    parameter logic [3:0] CLASS_CODE  = 4'hA,
    parameter logic [6:0] PAGE0_ADDR  = 7'h36,
    parameter logic [6:0] PAGE1_ADDR  = 7'h37,
    parameter int         ID_W        = 3,
    parameter int         SYNC_STAGES = 2,
    parameter int         PAGE_BYTES  = 256,
    parameter int         NUM_PAGES   = 2,
    localparam int        MEM_BYTES   = PAGE_BYTES * NUM_PAGES,
    localparam int        MEM_AW      = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   strap_id,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              pre_we,
    input  logic [MEM_AW-1:0] pre_addr,
    input  logic [BYTE_W-1:0] pre_data
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W:0]   rd_addr;
    logic [BYTE_W-1:0] rd_data;
    logic              page_w;
    logic [BYTE_W-1:0] ptr_w;
    tgt_state_e        st_w;

    spd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    spd_store #(.DEPTH(MEM_BYTES), .DATA_W(BYTE_W), .ADDR_W(MEM_AW)) u_store (
        .clk(clk), .we(pre_we), .waddr(pre_addr), .wdata(pre_data),
        .raddr(rd_addr), .rdata(rd_data)
    );

    spd_tgt_fsm #(
        .CLASS_CODE(CLASS_CODE), .PAGE0_ADDR(PAGE0_ADDR),
        .PAGE1_ADDR(PAGE1_ADDR), .ID_W(ID_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .strap_id(strap_id), .rd_data(rd_data), .rd_addr(rd_addr),
        .sda_oe(sda_oe), .page(page_w), .ptr(ptr_w), .st(st_w)
    );
endmodule

// File: rtl/spd_page_eeprom_chk.sv
module spd_page_eeprom_chk
    import spd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       page,
    input logic [7:0] ptr,
    input tgt_state_e st
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s); // R11
    AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe); // R9
    AST_PAGE_ON_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(page) |-> ($past(st) == ST_ADDR)); // R3
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st) == ST_RD_BYTE) && (st == ST_RD_ACK)) |-> (ptr == $past(ptr) + 8'd1)); // R6
    AST_RESET_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !page); // R1
endmodule

bind spd_page_eeprom spd_page_eeprom_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .page(page_w), .ptr(ptr_w), .st(st_w)
);

// File: tb/spd_page_eeprom_test.sv
module spd_page_eeprom_test;
    localparam int CLK_P = 10;
    localparam int QC    = 5;
    localparam logic [6:0] DEV_A = 7'h52;
    localparam logic [6:0] DEV_B = 7'h55;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_line = 1'b1;
    logic ctl_low = 1'b0;
    logic oe_a, oe_b;
    logic sda_line;
    logic pre_we_a = 1'b0, pre_we_b = 1'b0;
    logic [8:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    int nchk = 0, nfail = 0, oe_viol = 0;
    logic done = 1'b0;
    logic [7:0] got [0:7];

    always #(CLK_P/2) clk = ~clk;
    assign sda_line = !(ctl_low | oe_a | oe_b);

    spd_page_eeprom uut (
        .clk(clk), .rst_n(rst_n), .strap_id(3'd2), .scl_i(scl_line), .sda_i(sda_line),
        .sda_oe(oe_a), .pre_we(pre_we_a), .pre_addr(pre_addr), .pre_data(pre_data)
    );
    spd_page_eeprom uut_b (
        .clk(clk), .rst_n(rst_n), .strap_id(3'd5), .scl_i(scl_line), .sda_i(sda_line),
        .sda_oe(oe_b), .pre_we(pre_we_b), .pre_addr(pre_addr), .pre_data(pre_data)
    );

    function automatic logic [7:0] fa(input int a);
        return 8'((a * 37 + 11) ^ (a >> 1));
    endfunction
    function automatic logic [7:0] fb(input int a);
        return fa(a) ^ 8'h5A;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R11 monitor: output enable must not move while SCL is high
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && ((oe_a | oe_b) != oe_prev) && scl_line) oe_viol++;
        oe_prev <= oe_a | oe_b;
    end

    task automatic q();
        repeat (QC) @(negedge clk);
    endtask
    task automatic bus_start();
        q(); ctl_low = 1'b0; q(); scl_line = 1'b1; q(); ctl_low = 1'b1; q(); scl_line = 1'b0;
    endtask
    task automatic bus_stop();
        q(); ctl_low = 1'b1; q(); scl_line = 1'b1; q(); ctl_low = 1'b0; q();
    endtask
    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            q(); ctl_low = !b[i]; q(); scl_line = 1'b1; q(); q(); scl_line = 1'b0;
        end
        q(); ctl_low = 1'b0; q(); scl_line = 1'b1; q(); ack = !sda_line; q(); scl_line = 1'b0;
    endtask
    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            q(); ctl_low = 1'b0; q(); scl_line = 1'b1; q(); b[i] = sda_line; q(); scl_line = 1'b0;
        end
        q(); ctl_low = give_ack; q(); scl_line = 1'b1; q(); q(); scl_line = 1'b0;
    endtask

    task automatic query_page(output logic ack);
        bus_start();
        write_byte({7'h36, 1'b1}, ack);
        bus_stop();
    endtask

    task automatic rd_seq(input logic [6:0] dev, input logic [7:0] off, input int n, input string req);
        logic ack;
        bus_start();
        write_byte({dev, 1'b0}, ack); check({req, " addr-w ack"}, ack, 1);
        write_byte(off, ack);         check({req, " offset ack"}, ack, 1);
        bus_start();
        write_byte({dev, 1'b1}, ack); check({req, " addr-r ack"}, ack, 1);
        for (int k = 0; k < n; k++) read_byte(k != n - 1, got[k]);
        q();
        check("R9 sda released after final nack", int'(oe_a | oe_b), 0);
        bus_stop();
    endtask

    task automatic set_page(input logic [6:0] pa, input int extra);
        logic ack;
        bus_start();
        write_byte({pa, 1'b0}, ack); check("R3 page-select addr ack", ack, 1);
        for (int k = 0; k < extra; k++) begin
            write_byte(8'h6C ^ 8'(k), ack); check("R7 data after page addr ack", ack, 1);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        logic ack;
        check("R1 sda_oe a at reset", oe_a, 0);
        check("R1 sda_oe b at reset", oe_b, 0);
        query_page(ack);
        check("R1 page 0 after reset (query ack)", ack, 1);
    endtask

    task automatic t_address();
        logic ack;
        bus_start(); write_byte({7'h53, 1'b0}, ack); bus_stop();
        check("R2 unmatched addr 0x53 nack", ack, 0);
        bus_start(); write_byte({7'h37, 1'b1}, ack); bus_stop();
        check("R4 read to 0x37 nack", ack, 0);
        check("R2 sda released after nack", int'(oe_a | oe_b), 0);
        bus_start(); write_byte({DEV_A, 1'b0}, ack); bus_stop();
        check("R2 matched addr 0x52 ack", ack, 1);
    endtask

    task automatic t_random();
        rd_seq(DEV_A, 8'h40, 2, "R5");
        check("R5 a byte0 page0 off40", got[0], fa(9'h040));
        check("R5 a byte1 page0 off41", got[1], fa(9'h041));
        rd_seq(DEV_B, 8'h80, 1, "R5");
        check("R10 b preload page0 off80", got[0], fb(9'h080));
    endtask

    task automatic t_page();
        logic ack;
        set_page(7'h37, 0);
        query_page(ack); check("R4 query nack on page 1", ack, 0);
        rd_seq(DEV_A, 8'h05, 1, "R3");
        check("R3 a sees page 1", got[0], fa(9'h105));
        rd_seq(DEV_B, 8'h05, 1, "R3");
        check("R3 b sees page 1", got[0], fb(9'h105));
    endtask

    task automatic t_wrap();
        rd_seq(DEV_B, 8'hFE, 4, "R6");
        check("R6 off FE", got[0], fb(9'h1FE));
        check("R6 off FF", got[1], fb(9'h1FF));
        check("R6 wrap to 00 same page", got[2], fb(9'h100));
        check("R6 off 01", got[3], fb(9'h101));
    endtask

    task automatic t_page_data();
        logic ack;
        set_page(7'h37, 2);
        query_page(ack); check("R7 still page 1 after data bytes", ack, 0);
        rd_seq(DEV_A, 8'h20, 1, "R7");
        check("R7 a data from page 1", got[0], fa(9'h120));
        set_page(7'h36, 1);
        query_page(ack); check("R3 page 0 after 0x36 write", ack, 1);
        rd_seq(DEV_B, 8'h20, 1, "R3");
        check("R3 b back on page 0", got[0], fb(9'h020));
    endtask

    task automatic t_mem_write();
        logic ack;
        bus_start();
        write_byte({DEV_A, 1'b0}, ack); check("R8 addr ack", ack, 1);
        write_byte(8'h10, ack);         check("R8 offset ack", ack, 1);
        write_byte(8'hFF, ack);         check("R8 data byte ack", ack, 1);
        write_byte(8'h00, ack);         check("R8 second data byte ack", ack, 1);
        bus_stop();
        rd_seq(DEV_A, 8'h10, 2, "R8");
        check("R8 array unchanged off10", got[0], fa(9'h010));
        check("R8 array unchanged off11", got[1], fa(9'h011));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog all-requirements actual=hang expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        for (int a = 0; a < 512; a++) begin
            @(negedge clk);
            pre_addr = 9'(a); pre_data = fa(a); pre_we_a = 1'b1; pre_we_b = 1'b0;
            @(negedge clk);
            pre_data = fb(a); pre_we_a = 1'b0; pre_we_b = 1'b1;
        end
        @(negedge clk); pre_we_b = 1'b0;
        t_address();
        t_random();
        t_page();
        t_wrap();
        t_page_data();
        t_mem_write();
        check("R11 sda_oe moved while scl high", oe_viol, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule